// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns a single PWM waveform into a pair of drive signals, a true output and a complementary output, that are never high together. On each PWM transition, the output that must switch off does so on the next clock. The output that must switch on waits for a programmable dead time first. This gap lets external power switches turn off fully before their partners turn on.

The two dead times are programmed separately, so the true output's turn-on and the complementary output's turn-on can differ. Both delays are counted in ticks of a small prescaler that divides the timer clock by 1, 2, 4 or 8. The prescaler restarts at every PWM transition, so each dead time is a whole number of ticks measured from its edge. The block is meant to sit between a PWM compare stage and the output pin logic of a timer.

Top module: `dtg_top`

## Requirements
- R1: While `rst` is high, and after it is released until the first PWM transition, both outputs are low. The edge reference is low, so a high `pwm_in` on the first clock after reset counts as a rising transition.
- R2: `div_sel` chooses the prescaled tick period: 2'b00 gives 1 timer clock (no division), 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R3: When a rising transition of `pwm_in` is sampled at clock edge k, `out_comp` is low after edge k. `out_true` goes high after edge k + H·D, where H is `dt_word[7:4]` and D is the tick period from R2.
- R4: When a falling transition of `pwm_in` is sampled at clock edge k, `out_true` is low after edge k. `out_comp` goes high after edge k + L·D, where L is `dt_word[3:0]`.
- R5: A dead-time field of zero gives no delay: the output that turns on is high right after edge k.
- R6: If `pwm_in` changes again before a pending dead time has elapsed, that count is abandoned. Both outputs are low, and a new dead time is measured from the new edge.
- R7: The dead-time field and `div_sel` are captured at the PWM transition. Changing them while a count is running does not change that count.
- R8: `out_true` and `out_comp` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM waveform to be split |
| div_sel | input | 2 | Dead-time prescaler select |
| dt_word | input | 8 | Dead times: [7:4] for the true output, [3:0] for the complementary output |
| out_true | output | 1 | True drive output |
| out_comp | output | 1 | Complementary drive output |

## Verification
The assertions assume that `pwm_in`, `div_sel` and `dt_word` are synchronous to `clk` and stable around its rising edge. They also assume that a PWM transition is seen as a single-cycle difference from the registered copy of `pwm_in`. The bench changes every input only on the falling clock edge and holds `pwm_in` constant while a dead time is being measured. The exception is the abandon scenario, which retoggles on purpose in the middle of a count. Settings are changed in the middle of a count only in the capture scenario, where the measured delay must still match the values that were present at the edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Width of each dead-time field and of the prescaler select.
    localparam int DT_FIELD_W = 4;
    localparam int DIV_SEL_W  = 2;

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_BY8 = 2'b11
    } div_sel_e;

    // The upper field delays the true output, the lower field the complement.
    typedef struct packed {
        logic [DT_FIELD_W-1:0] rise_true;
        logic [DT_FIELD_W-1:0] rise_comp;
    } dt_fields_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pwm_edges_t;

    // Clock periods per prescaled tick: 2^sel.
    function automatic int div_ratio(input logic [DIV_SEL_W-1:0] sel);
        return 1 << sel;
    endfunction

endpackage

// File: rtl/dtg_edge.sv
module dtg_edge
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_in,
    output pwm_edges_t edges
);
    logic pwm_q;

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end

    always_comb begin
        edges.rise = pwm_in & ~pwm_q;
        edges.fall = ~pwm_in & pwm_q;
    end
endmodule

// File: rtl/dtg_prescaler.sv
module dtg_prescaler
    import dtg_pkg::*;
#(
    parameter int SEL_W = DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb last = CNT_W'(div_ratio(sel_q) - 1);
    always_comb tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt   <= '0;
        end else if (restart) begin
            sel_q <= sel;
            cnt   <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)) else $error("prescaler not restarted"); // R7
endmodule

// File: rtl/dtg_channel.sv
module dtg_channel
    import dtg_pkg::*;
#(
    parameter int FIELD_W = DT_FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               kill,
    input  logic [FIELD_W-1:0] delay,
    input  logic               tick,
    output logic               q
);
    logic               busy;
    logic [FIELD_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= 1'b0;
            busy   <= 1'b0;
            remain <= '0;
        end else if (kill) begin
            q      <= 1'b0;
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            remain <= delay;
            busy   <= (delay != '0);
            q      <= (delay == '0);
        end else if (busy && tick) begin
            remain <= remain - 1'b1;
            if (remain == FIELD_W'(1)) begin
                busy <= 1'b0;
                q    <= 1'b1;
            end
        end
    end

    AST_KILL_LOW: assert property (@(posedge clk) disable iff (rst)
        kill |=> !q) else $error("killed output high"); // R6
    AST_ZERO_NEXT: assert property (@(posedge clk) disable iff (rst)
        (start && !kill && delay == '0) |=> q) else $error("zero delay late"); // R5
    AST_DEAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (start && !kill && delay != '0) |=> !q) else $error("dead time skipped"); // R3
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter int FIELD_W = DT_FIELD_W,
    parameter int SEL_W   = DIV_SEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwm_in,
    input  logic [SEL_W-1:0]     div_sel,
    input  logic [2*FIELD_W-1:0] dt_word,
    output logic                 out_true,
    output logic                 out_comp
);
    localparam int NUM_CH = 2;

    pwm_edges_t         edges;
    logic               tick;
    logic               any_edge;
    logic [NUM_CH-1:0]  ch_q;
    logic [FIELD_W-1:0] field [NUM_CH];

    always_comb begin
        field[0] = dt_word[2*FIELD_W-1:FIELD_W];
        field[1] = dt_word[FIELD_W-1:0];
        any_edge = edges.rise | edges.fall;
    end

    dtg_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .edges  (edges)
    );

    dtg_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (any_edge),
        .sel     (div_sel),
        .tick    (tick)
    );

    // Channel 0 drives the true output and starts on a rising edge.
    // Channel 1 drives the complement and starts on a falling edge.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dtg_channel #(.FIELD_W(FIELD_W)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .start ((i == 0) ? edges.rise : edges.fall),
            .kill  ((i == 0) ? edges.fall : edges.rise),
            .delay (field[i]),
            .tick  (tick),
            .q     (ch_q[i])
        );
    end

    assign out_true = ch_q[0];
    assign out_comp = ch_q[1];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(out_true && out_comp)) else $error("outputs overlap"); // R8
    AST_RISE_DROPS_COMP: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !out_comp) else $error("comp high after rise"); // R3
    AST_FALL_DROPS_TRUE: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> !out_true) else $error("true high after fall"); // R4
endmodule

// File: tb/dtg_top_test.sv
module dtg_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic [7:0] dt_word = 8'h00;
    logic       out_true;
    logic       out_comp;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dtg_top uut (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .div_sel  (div_sel),
        .dt_word  (dt_word),
        .out_true (out_true),
        .out_comp (out_comp)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R8 monitored on every cycle.
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_true && out_comp) begin
                errors++;
                $display("FAIL R8 overlap: actual 1 expected 0");
            end
        end
    end

    // Toggle pwm to level, then count posedges until the turn-on output is high.
    task automatic run_edge(input string req, input logic level, input logic [7:0] dt,
                            input logic [1:0] sel, input int exp_edges);
        int cnt;
        cnt = 0;
        @(negedge clk);
        dt_word = dt;
        div_sel = sel;
        pwm_in  = level;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1)
                check(req, "turn-off output low after edge",
                      level ? int'(out_comp) : int'(out_true), 0);
        end while (!(level ? out_true : out_comp) && cnt < 300);
        check(req, "edges until turn-on", cnt, exp_edges);
    endtask

    task automatic test_reset();
        check("R1", "out_true in reset", out_true, 0);
        check("R1", "out_comp in reset", out_comp, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_true after reset idle", out_true, 0);
        check("R1", "out_comp after reset idle", out_comp, 0);
    endtask

    task automatic test_dividers();
        for (int s = 0; s < 4; s++) begin
            run_edge("R2", 1'b1, 8'h30, 2'(s), 3 * (1 << s) + 1);
            run_edge("R2", 1'b0, 8'h02, 2'(s), 2 * (1 << s) + 1);
        end
    endtask

    task automatic test_rise_fall();
        run_edge("R3", 1'b1, 8'hF1, 2'b01, 15 * 2 + 1);
        run_edge("R4", 1'b0, 8'h1F, 2'b00, 15 + 1);
        run_edge("R3", 1'b1, 8'h5A, 2'b10, 5 * 4 + 1);
        run_edge("R4", 1'b0, 8'h5A, 2'b11, 10 * 8 + 1);
    endtask

    task automatic test_zero();
        run_edge("R5", 1'b1, 8'h07, 2'b11, 1);
        run_edge("R5", 1'b0, 8'h70, 2'b11, 1);
    endtask

    task automatic test_abort();
        @(negedge clk);
        dt_word = 8'hF2;
        div_sel = 2'b11;
        pwm_in  = 1'b1;
        repeat (10) @(negedge clk);
        check("R6", "out_true during pending count", out_true, 0);
        check("R6", "out_comp during pending count", out_comp, 0);
        run_edge("R6", 1'b0, 8'hF2, 2'b11, 2 * 8 + 1);
        check("R6", "abandoned true never rose", out_true, 0);
    endtask

    task automatic test_capture();
        int cnt;
        cnt = 0;
        @(negedge clk);
        dt_word = 8'h40;
        div_sel = 2'b01;
        pwm_in  = 1'b1;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 3) begin
                dt_word = 8'h10;
                div_sel = 2'b00;
            end
        end while (!out_true && cnt < 300);
        check("R7", "delay uses settings from edge", cnt, 4 * 2 + 1);
        run_edge("R7", 1'b0, 8'h03, 2'b10, 3 * 4 + 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_dividers();
        test_rise_fall();
        test_zero();
        test_abort();
        test_capture();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule